// File: doc/BRIEF.md
# Banked Interrupt Controller Unit

This block gathers interrupt sources in banks of 32 and turns each bank into one interrupt request toward the processor. A source that is high on a clock edge latches a pending bit. Software sees the latched bits and clears them by writing ones. It sets an enable word per bank, and it reads the enabled pending bits as the work to do. Two more views are read-only: one shows the live source inputs and one shows which sources are masked. Every bank presents the same register layout, and successive banks sit at a fixed address stride.

Each bank drives its own request output, which is the registered OR of its enabled pending bits. Alongside it the bank gives a service vector: the index of its highest-numbered enabled pending source, registered in the same cycle as the request. A dispatcher can branch on the vector directly without scanning the status word. Bank 0 is meant for the processor's hardware interrupt line 2, bank 1 for line 3, and so on in bank order.

Top module: `icu_banked`

## Requirements
- R1: After reset every status and enable bit is 0, every request output and every vector output is 0, and the mask view of each bank reads 0xFFFFFFFF.
- R2: A source input that is high on a rising clock edge sets its pending bit at that edge. The bit stays set after the source falls, and it shows in the status register (offset 0x00).
- R3: Writing the status register clears exactly the pending bits written as 1. Bits written as 0 keep their value.
- R4: If a source sets a pending bit in the same cycle as a write that clears that bit, the bit ends up set.
- R5: The enable register (offset 0x08) takes the written word and reads it back. The mask view (offset 0x20) reads as the bitwise inverse of the enable register.
- R6: The output status view (offset 0x10) reads as the pending bits ANDed with the enable bits, and it reflects a change in either in the cycle after the edge that made the change.
- R7: A bank's request output is 1 exactly one clock edge after its output status becomes nonzero. It is 0 one edge after the output status becomes zero.
- R8: A bank's 5-bit vector output, registered together with the request, gives the index of the most significant set bit of the output status. It is 0 when the output status is 0.
- R9: Bank b occupies byte addresses 40*b to 40*b+39. An access to one bank never changes the registers, request or vector of another bank.
- R10: The raw source view (offset 0x18) reads the bank's current source inputs, whether or not they are pending or enabled.
- R11: Offsets other than the five listed above, misaligned addresses and addresses above the last bank read as 0 and ignore writes. Writes to the read-only views (0x10, 0x18, 0x20) change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (8) | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| src_i | input | NUM_BANKS*32 (160) | Interrupt sources; bank b uses bits 32*b to 32*b+31 |
| irq_o | output | NUM_BANKS (5) | Per-bank processor interrupt request |
| vec_o | output | NUM_BANKS*5 (25) | Per-bank service vector; bank b uses bits 5*b to 5*b+4 |

## Verification
A pending bit that is lost, stuck or set by the wrong source appears in the status read on the cycle after the edge that should have changed it. One edge later it appears on the request line, and the vector moves to the wrong index. A bad enable or wrong decode shows as the wrong word read back at a bank's offset, or as a request raised in a neighbouring bank. Every source bit of every bank is walked through set, enable, clear and disable, so a fault on any single bit or any bank shows within a few cycles of its own step. Priority, set-against-clear and unmapped-address cases are checked separately.

// File: rtl/icu_pkg.sv
package icu_pkg;

    localparam int ICU_SRC_W  = 32;
    localparam int ICU_IDX_W  = $clog2(ICU_SRC_W);
    localparam int ICU_BUS_W  = 32;
    localparam int ICU_STRIDE = 40;

    localparam int OFS_STATUS = 0;
    localparam int OFS_ENABLE = 8;
    localparam int OFS_OUTST  = 16;
    localparam int OFS_RAW    = 24;
    localparam int OFS_MASK   = 32;

    typedef enum logic [2:0] {
        REG_NONE   = 3'd0,
        REG_STATUS = 3'd1,
        REG_ENABLE = 3'd2,
        REG_OUTST  = 3'd3,
        REG_RAW    = 3'd4,
        REG_MASK   = 3'd5
    } icu_reg_e;

    typedef struct packed {
        logic                 wr;
        icu_reg_e             kind;
        logic [ICU_BUS_W-1:0] wdata;
    } icu_req_t;

    function automatic icu_reg_e icu_decode_offset(input int off);
        icu_reg_e k;
        case (off)
            OFS_STATUS: k = REG_STATUS;
            OFS_ENABLE: k = REG_ENABLE;
            OFS_OUTST:  k = REG_OUTST;
            OFS_RAW:    k = REG_RAW;
            OFS_MASK:   k = REG_MASK;
            default:    k = REG_NONE;
        endcase
        return k;
    endfunction

    function automatic logic [ICU_SRC_W-1:0] icu_next_pend(
        input logic [ICU_SRC_W-1:0] pend,
        input logic [ICU_SRC_W-1:0] set_bits,
        input logic [ICU_SRC_W-1:0] clr_bits
    );
        return (pend & ~clr_bits) | set_bits;
    endfunction

endpackage

// File: rtl/icu_addr_dec.sv
module icu_addr_dec
    import icu_pkg::*;
#(
    parameter int NUM_BANKS = 5,
    parameter int ADDR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_BANKS-1:0] bank_sel,
    output icu_reg_e             kind
);

    localparam int SPAN = NUM_BANKS * ICU_STRIDE;

    always_comb begin
        bank_sel = '0;
        kind     = REG_NONE;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (int'(addr) >= b * ICU_STRIDE && int'(addr) < (b + 1) * ICU_STRIDE) begin
                bank_sel[b] = 1'b1;
                kind        = icu_decode_offset(int'(addr) - b * ICU_STRIDE);
            end
        end
    end

    AST_DEC_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (kind != REG_NONE) |-> (addr[1:0] == 2'b00)); // R11

    AST_DEC_OUT_OF_SPAN: assert property (@(posedge clk) disable iff (rst)
        (int'(addr) >= SPAN) |-> (kind == REG_NONE)); // R11

endmodule

// File: rtl/icu_msb_enc.sv
module icu_msb_enc #(
    parameter int WIDTH = 32,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] bits,
    output logic [IDX_W-1:0] idx,
    output logic             any
);

    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = 0; i < WIDTH; i++) begin
            if (bits[i]) begin
                idx = IDX_W'(i);
                any = 1'b1;
            end
        end
    end

endmodule

// File: rtl/icu_bank.sv
module icu_bank
    import icu_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sel,
    input  icu_req_t             req,
    input  logic [ICU_SRC_W-1:0] src,
    output logic [ICU_BUS_W-1:0] rdata,
    output logic                 irq,
    output logic [ICU_IDX_W-1:0] vec
);

    logic [ICU_SRC_W-1:0] pend_q;
    logic [ICU_SRC_W-1:0] en_q;
    logic [ICU_SRC_W-1:0] outst;
    logic [ICU_SRC_W-1:0] clr;
    logic [ICU_IDX_W-1:0] top_idx;
    logic                 top_any;
    logic                 wr_en;

    assign outst = pend_q & en_q;
    assign clr   = (sel && req.wr && req.kind == REG_STATUS) ? req.wdata : '0;
    assign wr_en = sel && req.wr && req.kind == REG_ENABLE;

    icu_msb_enc #(.WIDTH(ICU_SRC_W)) enc_i (
        .bits (outst),
        .idx  (top_idx),
        .any  (top_any)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            en_q   <= '0;
            irq    <= 1'b0;
            vec    <= '0;
        end else begin
            pend_q <= icu_next_pend(pend_q, src, clr);
            if (wr_en) begin
                en_q <= req.wdata;
            end
            irq <= top_any;
            vec <= top_idx;
        end
    end

    always_comb begin
        rdata = '0;
        if (sel) begin
            case (req.kind)
                REG_STATUS: rdata = pend_q;
                REG_ENABLE: rdata = en_q;
                REG_OUTST:  rdata = outst;
                REG_RAW:    rdata = src;
                REG_MASK:   rdata = ~en_q;
                default:    rdata = '0;
            endcase
        end
    end

    AST_SRC_SETS_PEND: assert property (@(posedge clk) disable iff (rst)
        (src != '0) |=> ((pend_q & $past(src)) == $past(src))); // R2

    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (rst)
        (src == '0) |=> ((pend_q & ~$past(pend_q)) == '0)); // R2

    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
        (clr != '0) |=> ((pend_q & $past(clr & ~src)) == '0)); // R3

    AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (rst)
        ((clr & src) != '0) |=> ((pend_q & $past(clr & src)) == $past(clr & src))); // R4

    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
        (outst != '0) |=> irq); // R7

    AST_IRQ_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (outst == '0) |=> !irq); // R7

    AST_VEC_TOP: assert property (@(posedge clk) disable iff (rst)
        irq |-> (($past(outst) >> vec) == 32'd1)); // R8

endmodule

// File: rtl/icu_banked.sv
module icu_banked
    import icu_pkg::*;
#(
    parameter int NUM_BANKS = 5,
    parameter int ADDR_W    = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic                           bus_wr,
    input  logic [ICU_BUS_W-1:0]           bus_wdata,
    output logic [ICU_BUS_W-1:0]           bus_rdata,
    input  logic [NUM_BANKS*ICU_SRC_W-1:0] src_i,
    output logic [NUM_BANKS-1:0]           irq_o,
    output logic [NUM_BANKS*ICU_IDX_W-1:0] vec_o
);

    logic [NUM_BANKS-1:0] bank_sel;
    icu_reg_e             kind;
    icu_req_t             req;
    logic [ICU_BUS_W-1:0] bank_rdata [NUM_BANKS];

    icu_addr_dec #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) dec_i (
        .clk      (clk),
        .rst      (rst),
        .addr     (bus_addr),
        .bank_sel (bank_sel),
        .kind     (kind)
    );

    assign req.wr    = bus_wr;
    assign req.kind  = kind;
    assign req.wdata = bus_wdata;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        icu_bank bank_i (
            .clk   (clk),
            .rst   (rst),
            .sel   (bank_sel[b]),
            .req   (req),
            .src   (src_i[b*ICU_SRC_W +: ICU_SRC_W]),
            .rdata (bank_rdata[b]),
            .irq   (irq_o[b]),
            .vec   (vec_o[b*ICU_IDX_W +: ICU_IDX_W])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            bus_rdata = bus_rdata | bank_rdata[b];
        end
    end

endmodule

// File: tb/icu_banked_tb_top.sv
module icu_banked_tb_top;

    localparam int NB     = 5;
    localparam int STRIDE = 40;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [7:0]        bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NB*32-1:0]  src_i = '0;
    logic [NB-1:0]     irq_o;
    logic [NB*5-1:0]   vec_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    icu_banked dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_i     (src_i),
        .irq_o     (irq_o),
        .vec_o     (vec_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input int addr, input logic [31:0] data);
        @(negedge clk);
        bus_addr  = 8'(addr);
        bus_wdata = data;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic bus_read(input int addr, output logic [31:0] data);
        bus_addr = 8'(addr);
        #1;
        data = bus_rdata;
    endtask

    task automatic pulse(input int b, input logic [31:0] bits);
        @(negedge clk);
        src_i[b*32 +: 32] = bits;
        @(negedge clk);
        src_i[b*32 +: 32] = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state of every bank
        for (int b = 0; b < NB; b++) begin
            bus_read(b*STRIDE + 0, rd);  check("R1 status", rd, 32'h0);
            bus_read(b*STRIDE + 8, rd);  check("R1 enable", rd, 32'h0);
            bus_read(b*STRIDE + 32, rd); check("R1 mask", rd, 32'hFFFF_FFFF);
        end
        check("R1 irq", 32'(irq_o), 32'h0);
        check("R1 vec", 32'(vec_o), 32'h0);

        // Sweep every bit of every bank
        for (int b = 0; b < NB; b++) begin
            for (int i = 0; i < 32; i++) begin
                logic [31:0] bit_m;
                int base;
                base  = b*STRIDE;
                bit_m = 32'd1 << i;
                pulse(b, bit_m);
                bus_read(base + 0, rd);  check("R2 latched", rd, bit_m);
                bus_read(base + 16, rd); check("R6 disabled", rd, 32'h0);
                @(negedge clk);
                check("R7 no irq disabled", 32'(irq_o), 32'h0);
                bus_write(base + 8, bit_m);
                bus_read(base + 8, rd);  check("R5 enable", rd, bit_m);
                bus_read(base + 32, rd); check("R5 mask", rd, ~bit_m);
                bus_read(base + 16, rd); check("R6 outst", rd, bit_m);
                check("R7 latency", 32'(irq_o), 32'h0);
                @(negedge clk);
                check("R7 irq", 32'(irq_o), 32'd1 << b);
                check("R8 vec", 32'(vec_o[b*5 +: 5]), 32'(i));
                bus_read(((b+1)%NB)*STRIDE + 8, rd); check("R9 neighbour", rd, 32'h0);
                bus_write(base + 0, ~bit_m);
                bus_read(base + 0, rd);  check("R3 zero keeps", rd, bit_m);
                bus_write(base + 0, bit_m);
                bus_read(base + 0, rd);  check("R3 cleared", rd, 32'h0);
                check("R7 irq held one edge", 32'(irq_o), 32'd1 << b);
                @(negedge clk);
                check("R7 irq drop", 32'(irq_o), 32'h0);
                check("R8 vec idle", 32'(vec_o[b*5 +: 5]), 32'h0);
                bus_write(base + 8, 32'h0);
            end
        end

        // R8: priority among several sources in bank 2
        bus_write(2*STRIDE + 8, 32'hFFFF_FFFF);
        pulse(2, (32'd1 << 3) | (32'd1 << 17) | (32'd1 << 9));
        @(negedge clk);
        check("R8 top of three", 32'(vec_o[10 +: 5]), 32'd17);
        bus_write(2*STRIDE + 0, 32'd1 << 17);
        check("R8 pre-update", 32'(vec_o[10 +: 5]), 32'd17);
        @(negedge clk);
        check("R8 next highest", 32'(vec_o[10 +: 5]), 32'd9);
        pulse(2, 32'h8000_0001);
        @(negedge clk);
        check("R8 bit 31", 32'(vec_o[10 +: 5]), 32'd31);
        bus_read(2*STRIDE + 16, rd); check("R6 multi", rd, 32'h8000_0209);
        bus_write(2*STRIDE + 0, 32'hFFFF_FFFF);
        bus_read(2*STRIDE + 0, rd); check("R3 clear all", rd, 32'h0);
        bus_write(2*STRIDE + 8, 32'h0);

        // R4: set wins over clear in the same cycle
        pulse(4, 32'd1 << 6);
        @(negedge clk);
        bus_addr  = 8'(4*STRIDE);
        bus_wdata = (32'd1 << 5) | (32'd1 << 6);
        bus_wr    = 1'b1;
        src_i[4*32 + 5] = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        src_i[4*32 + 5] = 1'b0;
        bus_read(4*STRIDE, rd); check("R4 set wins", rd, 32'd1 << 5);
        bus_write(4*STRIDE, 32'hFFFF_FFFF);

        // R10: raw source view
        @(negedge clk);
        src_i[32 +: 32] = 32'hA5A5_0F0F;
        bus_read(STRIDE + 24, rd); check("R10 raw live", rd, 32'hA5A5_0F0F);
        @(negedge clk);
        src_i[32 +: 32] = '0;
        bus_read(STRIDE + 24, rd); check("R10 raw low", rd, 32'h0);
        bus_read(STRIDE + 0, rd);  check("R2 raw latched", rd, 32'hA5A5_0F0F);
        bus_write(STRIDE + 0, 32'hFFFF_FFFF);

        // R11: unmapped, misaligned, beyond span, read-only views
        bus_write(4, 32'hFFFF_FFFF);
        bus_read(4, rd);          check("R11 gap read", rd, 32'h0);
        bus_write(9, 32'hFFFF_FFFF);
        bus_read(9, rd);          check("R11 misaligned", rd, 32'h0);
        bus_write(16, 32'hFFFF_FFFF);
        bus_write(32, 32'h0);
        bus_read(8, rd);          check("R11 enable untouched", rd, 32'h0);
        bus_read(32, rd);         check("R11 mask untouched", rd, 32'hFFFF_FFFF);
        bus_read(NB*STRIDE, rd);  check("R11 beyond span", rd, 32'h0);
        bus_read(255, rd);        check("R11 top address", rd, 32'h0);
        for (int b = 0; b < NB; b++) begin
            bus_read(b*STRIDE, rd); check("R9 status clean", rd, 32'h0);
        end
        check("R9 irq quiet", 32'(irq_o), 32'h0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule